// File: doc/BRIEF.md
# System Control GPIO and Interrupt Unit

This block is a byte-addressed register file that sits on an 8-bit control bus. It drives a bank of general-purpose output pins and gathers level-sensitive requests from up to eight internal sub-devices into a single host interrupt line. Each pin's value comes from a data word and an output-enable word. Both words are split into 8-bit lanes. A pin is driven high only when both its data bit and its enable bit are set. Whenever a pin's driven value changes, a one-cycle change pulse appears on that pin's event line.

The interrupt side keeps a status byte that follows the request lines and a mask byte that software writes. The host line is raised while any request that is not masked is active. A read-only revision byte identifies the unit. Routing, clock control, function enable and mode control registers are plain storage with no effect on the hardware. Software uses them as scratch state for configuration that lives elsewhere in the chip.

Bus accesses are single-byte. Writes take effect at the clock edge on which they are sampled. Read data is registered and appears on the clock after the read strobe.

Top module: `sysctl_unit`

## Requirements
- R1: While reset is held and right after it, the outputs `gpio_pins`, `gpio_evt`, `host_irq` and `rdata` are 0. The data, enable and mask registers also read back 0.
- R2: A read of offset 0x08 returns the revision parameter `REV_ID` (default 0x3A). A write there has no effect.
- R3: Output data lane n lives at offset 0x78+n, for n = 0..2, and holds bits 8n+7..8n. A byte write changes only its own lane. Lane 2 (bits 23..16) is stored and reads back, but it drives no pin.
- R4: Output enable lane n lives at offset 0x7C+n, for n = 0..2, with the same lane rules as R3.
- R5: `gpio_pins` equals the low 16 bits of (data AND enable). It shows a write one clock after the edge that sampled the write.
- R6: Each bit of `gpio_evt` pulses high for exactly one clock, in the same cycle that the matching `gpio_pins` bit takes a new value. A write that leaves a pin unchanged gives no pulse on that pin.
- R7: Bit i of the interrupt status byte at 0x50 follows request line `irq_req[i]` with one clock of delay. Writes to 0x50 have no effect.
- R8: `host_irq` is high one clock after the status byte ANDed with the mask byte at 0x52 is nonzero, and low one clock after that AND is zero.
- R9: The 16-bit clock control word at 0x98/0x99 and the mode word at 0xE4/0xE5 are little-endian, with the low byte at the lower offset. A write to one byte keeps the other byte.
- R10: The routing byte at 0x54 and the function enable byte at 0xE0 read back exactly what was last written.
- R11: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and no output.
- R12: `rdata` loads the addressed byte on the clock edge that samples `rd_en`. It holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_req | input | NUM_IRQ (8) | Level request lines from the sub-devices |
| host_irq | output | 1 | Combined host interrupt, registered |
| gpio_pins | output | NUM_GPIO (16) | Driven output levels (data AND enable) |
| gpio_evt | output | NUM_GPIO (16) | One-cycle pulse per pin whose level changed |

## Verification
Register writes are visible on a read one edge after the write is sampled. Read data arrives one edge after the read strobe. The pins and their change pulses appear one edge after the register update, so they come two edges after the write strobe. The status byte trails a request line by one edge, and the host line trails the status/mask AND by one more edge, two edges in all. The bench drives inputs at the falling clock edge and counts the rising edges required for each path before it samples. It also samples one edge later to confirm that each pulse has dropped.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [7:0] OFS_REV     = 8'h08;
  localparam logic [7:0] OFS_ISTAT   = 8'h50;
  localparam logic [7:0] OFS_IMASK   = 8'h52;
  localparam logic [7:0] OFS_IROUTE  = 8'h54;
  localparam logic [7:0] OFS_GPO_DAT = 8'h78;
  localparam logic [7:0] OFS_GPO_OE  = 8'h7C;
  localparam logic [7:0] OFS_CLKCTL  = 8'h98;
  localparam logic [7:0] OFS_FUNCEN  = 8'hE0;
  localparam logic [7:0] OFS_MODE    = 8'hE4;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
  } sc_wr_t;
endpackage

// File: rtl/sysctl_byte_reg.sv
// Multi-byte register built of independent byte lanes, little-endian.
module sysctl_byte_reg
  import sysctl_pkg::*;
#(
  parameter int         NBYTES = 2,
  parameter logic [7:0] BASE   = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  sc_wr_t                wr,
  input  logic [7:0]            rd_addr,
  output logic [8*NBYTES-1:0]   value,
  output logic [7:0]            rd_byte
);
  logic [7:0] lane_q [NBYTES];
  logic [7:0] rd_ofs;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam logic [7:0] LANE_ADDR = BASE + 8'(b);
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[b] <= '0;
      else if (wr.wr && wr.addr == LANE_ADDR)
        lane_q[b] <= wr.data;
    end
    assign value[8*b +: 8] = lane_q[b];
  end

  assign rd_ofs = rd_addr - BASE;

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (rd_ofs == 8'(b)) rd_byte = lane_q[b];
  end
endmodule

// File: rtl/sysctl_gpio_out.sv
// Output data/enable lanes, effective level and per-pin change pulses.
module sysctl_gpio_out
  import sysctl_pkg::*;
#(
  parameter int NUM_GPIO = 16,
  parameter int LANES    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sc_wr_t               wr,
  input  logic [7:0]           rd_addr,
  output logic [7:0]           rd_byte,
  output logic [8*LANES-1:0]   eff_word,
  output logic [NUM_GPIO-1:0]  pins,
  output logic [NUM_GPIO-1:0]  evt
);
  localparam int W = 8 * LANES;

  logic [W-1:0] data_w, oe_w;
  logic [7:0]   data_rd, oe_rd;
  logic [NUM_GPIO-1:0] pins_q, evt_q;

  sysctl_byte_reg #(.NBYTES(LANES), .BASE(OFS_GPO_DAT)) u_data (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr),
    .value(data_w), .rd_byte(data_rd));

  sysctl_byte_reg #(.NBYTES(LANES), .BASE(OFS_GPO_OE)) u_oe (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr),
    .value(oe_w), .rd_byte(oe_rd));

  assign eff_word = data_w & oe_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      evt_q  <= '0;
    end else begin
      pins_q <= eff_word[NUM_GPIO-1:0];
      evt_q  <= eff_word[NUM_GPIO-1:0] ^ pins_q;
    end
  end

  assign pins    = pins_q;
  assign evt     = evt_q;
  assign rd_byte = data_rd | oe_rd;
endmodule

// File: rtl/sysctl_irq_agg.sv
// Level-following interrupt status, mask byte and combined host line.
module sysctl_irq_agg
  import sysctl_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  sc_wr_t             wr,
  input  logic [7:0]         rd_addr,
  input  logic [NUM_IRQ-1:0] req,
  output logic [7:0]         rd_byte,
  output logic [NUM_IRQ-1:0] status,
  output logic [NUM_IRQ-1:0] mask,
  output logic               host_irq
);
  logic [NUM_IRQ-1:0] status_q;
  logic [7:0]         mask_w, mask_rd, st8;
  logic               host_q;

  sysctl_byte_reg #(.NBYTES(1), .BASE(OFS_IMASK)) u_mask (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr),
    .value(mask_w), .rd_byte(mask_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      host_q   <= 1'b0;
    end else begin
      status_q <= req;
      host_q   <= |(status_q & mask_w[NUM_IRQ-1:0]);
    end
  end

  always_comb begin
    st8 = '0;
    st8[NUM_IRQ-1:0] = status_q;
  end

  assign rd_byte  = mask_rd | ((rd_addr == OFS_ISTAT) ? st8 : 8'h00);
  assign status   = status_q;
  assign mask     = mask_w[NUM_IRQ-1:0];
  assign host_irq = host_q;
endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter int         NUM_GPIO  = 16,
  parameter int         GPO_LANES = 3,
  parameter int         NUM_IRQ   = 8,
  parameter logic [7:0] REV_ID    = 8'h3A
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic [NUM_IRQ-1:0]  irq_req,
  output logic                host_irq,
  output logic [NUM_GPIO-1:0] gpio_pins,
  output logic [NUM_GPIO-1:0] gpio_evt
);
  sc_wr_t wr;
  logic [7:0] gpio_rd, irq_rd, route_rd, clk_rd, fen_rd, mode_rd, rev_rd, rd_mux;
  logic [8*GPO_LANES-1:0] gpio_eff;
  logic [NUM_IRQ-1:0] irq_status, irq_mask;
  logic [7:0]  route_w, fen_w;
  logic [15:0] clk_w, mode_w;
  logic [7:0]  rdata_q;

  assign wr = '{wr: wr_en, addr: addr, data: wdata};

  sysctl_gpio_out #(.NUM_GPIO(NUM_GPIO), .LANES(GPO_LANES)) u_gpio (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(addr), .rd_byte(gpio_rd),
    .eff_word(gpio_eff), .pins(gpio_pins), .evt(gpio_evt));

  sysctl_irq_agg #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(addr), .req(irq_req),
    .rd_byte(irq_rd), .status(irq_status), .mask(irq_mask),
    .host_irq(host_irq));

  sysctl_byte_reg #(.NBYTES(1), .BASE(OFS_IROUTE)) u_route (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(addr),
    .value(route_w), .rd_byte(route_rd));

  sysctl_byte_reg #(.NBYTES(2), .BASE(OFS_CLKCTL)) u_clkctl (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(addr),
    .value(clk_w), .rd_byte(clk_rd));

  sysctl_byte_reg #(.NBYTES(1), .BASE(OFS_FUNCEN)) u_funcen (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(addr),
    .value(fen_w), .rd_byte(fen_rd));

  sysctl_byte_reg #(.NBYTES(2), .BASE(OFS_MODE)) u_mode (
    .clk(clk), .rst(rst), .wr(wr), .rd_addr(addr),
    .value(mode_w), .rd_byte(mode_rd));

  assign rev_rd = (addr == OFS_REV) ? REV_ID : 8'h00;
  assign rd_mux = gpio_rd | irq_rd | route_rd | clk_rd | fen_rd | mode_rd | rev_rd;

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_en)
      rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk #(
  parameter int         NUM_GPIO  = 16,
  parameter int         GPO_LANES = 3,
  parameter int         NUM_IRQ   = 8,
  parameter logic [7:0] REV_ID    = 8'h3A
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rd_en,
  input logic [7:0]             addr,
  input logic [7:0]             rdata,
  input logic [NUM_IRQ-1:0]     irq_req,
  input logic                   host_irq,
  input logic [NUM_GPIO-1:0]    gpio_pins,
  input logic [NUM_GPIO-1:0]    gpio_evt,
  input logic [NUM_IRQ-1:0]     irq_status,
  input logic [NUM_IRQ-1:0]     irq_mask,
  input logic [8*GPO_LANES-1:0] gpio_eff
);
  logic [NUM_GPIO-1:0] eff_lo;
  assign eff_lo = gpio_eff[NUM_GPIO-1:0];

  // R5
  a_r5_pins_follow_eff: assert property (@(posedge clk) disable iff (rst)
    gpio_pins == $past(eff_lo));
  // R6
  a_r6_evt_is_change: assert property (@(posedge clk) disable iff (rst)
    gpio_evt == (gpio_pins ^ $past(gpio_pins)));
  // R7
  a_r7_status_tracks_req: assert property (@(posedge clk) disable iff (rst)
    irq_status == $past(irq_req));
  // R8
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((irq_status & irq_mask) == '0) |=> !host_irq);
  a_r8_unmasked_raises: assert property (@(posedge clk) disable iff (rst)
    ((irq_status & irq_mask) != '0) |=> host_irq);
  // R2
  a_r2_rev_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 8'h08) |=> rdata == REV_ID);
  // R12
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind sysctl_unit sysctl_unit_chk #(
  .NUM_GPIO(NUM_GPIO), .GPO_LANES(GPO_LANES), .NUM_IRQ(NUM_IRQ), .REV_ID(REV_ID)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_req(irq_req), .host_irq(host_irq), .gpio_pins(gpio_pins),
  .gpio_evt(gpio_evt), .irq_status(irq_status), .irq_mask(irq_mask),
  .gpio_eff(gpio_eff));

// File: tb/test_sysctl_unit.sv
`timescale 1ns/1ps
module test_sysctl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  irq_req = '0;
  logic        host_irq;
  logic [15:0] gpio_pins, gpio_evt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sysctl_unit i_sysctl_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .host_irq(host_irq),
    .gpio_pins(gpio_pins), .gpio_evt(gpio_evt));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // write sampled at one edge; returns just after it
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pins", gpio_pins, 0);
    chk("R1 evt", gpio_evt, 0);
    chk("R1 host_irq", host_irq, 0);
    chk("R1 rdata", rdata, 0);
    rd(8'h78, v); chk("R1 data lane0", v, 0);
    rd(8'h7C, v); chk("R1 enable lane0", v, 0);
    rd(8'h52, v); chk("R1 mask", v, 0);
  endtask

  task automatic t_rev;
    logic [7:0] v;
    rd(8'h08, v); chk("R2 revision", v, 8'h3A);
    wr(8'h08, 8'h00);
    rd(8'h08, v); chk("R2 revision after write", v, 8'h3A);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    wr(8'h78, 8'hA5);
    step(1);
    chk("R5 data only, enable 0", gpio_pins, 16'h0000);
    chk("R6 no change no pulse", gpio_evt, 16'h0000);
    wr(8'h7C, 8'h0F);
    step(1);
    chk("R5 pins lane0", gpio_pins, 16'h0005);
    chk("R6 pulse lane0", gpio_evt, 16'h0005);
    step(1);
    chk("R6 pulse one cycle", gpio_evt, 16'h0000);
    wr(8'h7D, 8'hFF);
    step(1);
    chk("R4 enable lane1 no pin change", gpio_pins, 16'h0005);
    chk("R6 no pulse on unchanged pins", gpio_evt, 16'h0000);
    wr(8'h79, 8'h3C);
    step(1);
    chk("R5 pins lane1", gpio_pins, 16'h3C05);
    chk("R6 pulse lane1 only", gpio_evt, 16'h3C00);
    rd(8'h78, v); chk("R3 lane0 kept", v, 8'hA5);
    rd(8'h79, v); chk("R3 lane1 stored", v, 8'h3C);
    rd(8'h7C, v); chk("R4 enable lane0 kept", v, 8'h0F);
    wr(8'h7A, 8'hFF);
    wr(8'h7E, 8'hFF);
    step(1);
    chk("R3 lane2 drives no pin", gpio_pins, 16'h3C05);
    chk("R6 lane2 no pulse", gpio_evt, 16'h0000);
    rd(8'h7A, v); chk("R3 lane2 readback", v, 8'hFF);
    rd(8'h7E, v); chk("R4 enable lane2 readback", v, 8'hFF);
    wr(8'h7C, 8'h00);
    step(1);
    chk("R5 enable clear drops pins", gpio_pins, 16'h3C00);
    chk("R6 falling pulses", gpio_evt, 16'h0005);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    @(negedge clk); irq_req = 8'h05;
    @(negedge clk);
    rd(8'h50, v); chk("R7 status follows req", v, 8'h05);
    chk("R8 no irq with mask 0", host_irq, 0);
    wr(8'h52, 8'h04);
    step(1);
    chk("R8 irq raised", host_irq, 1);
    wr(8'h50, 8'hFF);
    rd(8'h50, v); chk("R7 status write ignored", v, 8'h05);
    @(negedge clk); irq_req = 8'h01;
    @(negedge clk);
    chk("R8 not yet dropped", host_irq, 1);
    @(negedge clk);
    chk("R8 irq dropped", host_irq, 0);
    rd(8'h50, v); chk("R7 status cleared bit", v, 8'h01);
    @(negedge clk); irq_req = 8'h00;
  endtask

  task automatic t_storage;
    logic [7:0] v;
    wr(8'h98, 8'h34); wr(8'h99, 8'h12); wr(8'h98, 8'h56);
    rd(8'h98, v); chk("R9 clock low", v, 8'h56);
    rd(8'h99, v); chk("R9 clock high kept", v, 8'h12);
    wr(8'hE5, 8'h9A); wr(8'hE4, 8'hBC);
    rd(8'hE5, v); chk("R9 mode high kept", v, 8'h9A);
    rd(8'hE4, v); chk("R9 mode low", v, 8'hBC);
    wr(8'h54, 8'h6E);
    rd(8'h54, v); chk("R10 routing", v, 8'h6E);
    wr(8'hE0, 8'hC3);
    rd(8'hE0, v); chk("R10 function enable", v, 8'hC3);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(8'h40, 8'hAA);
    step(1);
    rd(8'h40, v); chk("R11 unmapped read 0", v, 8'h00);
    rd(8'h09, v); chk("R11 unmapped read 0 near rev", v, 8'h00);
    chk("R11 pins unaffected", gpio_pins, 16'h3C00);
    rd(8'h54, v); chk("R11 routing unaffected", v, 8'h6E);
  endtask

  task automatic t_rdata_hold;
    logic [7:0] v;
    rd(8'h54, v); chk("R12 read loads", v, 8'h6E);
    @(negedge clk); addr = 8'h08;
    @(negedge clk);
    chk("R12 rdata holds without rd_en", rdata, 8'h6E);
  endtask

  initial begin
    step(3);
    t_reset;
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_rev;
    t_gpio;
    t_irq;
    t_storage;
    t_unmapped;
    t_rdata_hold;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule